// File: doc/BRIEF.md
# Serially Configured Dual Look-Up-Table Logic Cell

This block is a small programmable logic cell holding two look-up tables, each with three select inputs and two outputs. The table contents and one routing choice are loaded as a serial bitstream. Loading uses a dedicated configuration clock and a single serial data pin. Once loaded, the cell is purely combinational: the data inputs index the stored tables, and the selected entries appear at the outputs with no clock involved.

The cell has a "right" table driven by `a_in` and a "left" table driven by `b_in`. A configuration bit can replace the left table's top select input with the right table's upper output. This chains the two tables. One use is a 2-bit ripple-carry adder:

- The right table produces sum bit 0 and an internal carry.
- The left table consumes that carry and produces sum bit 1 and the carry-out.

All four table outputs are brought to ports.

Top module: `lut_pair_cell`

## Requirements
- R1: While `cfg_rst_n` is low, the configuration chain is held at all zeros. With an all-zero chain, `r_out` and `l_out` are 0 for every data input.
- R2: On each rising edge of `cfg_clk` (reset released), the 33-bit chain shifts one place toward its most significant bit, and `cfg_sin` enters at bit 0.
- R3: Chain layout:
  - bits 32..17 hold the right table;
  - bits 16..1 hold the left table;
  - bit 0 is the chain-select bit.
  
  A configuration word {right[15:0], left[15:0], sel} is therefore loaded most significant bit first in 33 clocks.
- R4: Within a 16-bit table, entry k occupies bits 2k+1..2k. Bit 2k drives output bit 0, and bit 2k+1 drives output bit 1.
- R5: `r_out` equals the right-table entry at index `a_in` ({a_in[2], a_in[1], a_in[0]}), combinationally.
- R6: With the chain-select bit at 0, `l_out` equals the left-table entry at index `b_in`.
- R7: With the chain-select bit at 1, the left index is {r_out[1], b_in[1], b_in[0]}, and `b_in[2]` has no effect on any output.
- R8: When `cfg_clk` does not toggle, the configuration holds: neither `cfg_sin` nor changes on the data inputs alter the stored tables.
- R9: When loaded with a full-adder table in both tables and the chain-select bit set, the cell adds two 2-bit operands plus a carry-in:
  - the right table takes {cin, b0, a0} on `a_in`;
  - the left table takes b1 and a1 on `b_in[1:0]`;
  - {l_out[1], l_out[0], r_out[0]} equals a + b + cin.
- R10: Bits shifted in beyond 33 push the oldest bits out of bit 32, where they are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_rst_n | input | 1 | Active-low asynchronous clear of the configuration chain |
| cfg_sin | input | 1 | Serial configuration data |
| a_in | input | 3 | Select inputs of the right table |
| b_in | input | 3 | Select inputs of the left table |
| r_out | output | 2 | Right table outputs |
| l_out | output | 2 | Left table outputs |

## Verification
A wrong bit in the chain stays hidden until a data input selects the entry holding it. It then shows at once and combinationally on one output bit. For this reason, every loaded configuration is swept over all input combinations.

A misplaced chain-select bit corrupts only the left outputs, and only when `b_in[2]` and `r_out[1]` differ. An off-by-one in shifting shifts every entry, so the next sweep exposes it.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
    localparam int LUT_IN     = 3;
    localparam int LUT_OUT    = 2;
    localparam int ENTRIES    = 1 << LUT_IN;
    localparam int TBL_BITS   = ENTRIES * LUT_OUT;
    localparam int N_TABLES   = 2;
    localparam int CHAIN_LEN  = N_TABLES * TBL_BITS + 1;
    localparam int SEL_POS    = 0;
    localparam int LEFT_LSB   = 1;
    localparam int RIGHT_LSB  = LEFT_LSB + TBL_BITS;
endpackage

// File: rtl/lutcell_chain.sv
module lutcell_chain #(
    parameter int LEN = lutcell_pkg::CHAIN_LEN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sin,
    output logic [LEN-1:0] bits
);
    typedef struct packed {
        logic [LEN-1:0] sr;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sr = {st_q.sr[LEN-2:0], sin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits = st_q.sr;
endmodule

// File: rtl/lutcell_table.sv
module lutcell_table #(
    parameter int IN  = lutcell_pkg::LUT_IN,
    parameter int OUT = lutcell_pkg::LUT_OUT,
    localparam int NENT = 1 << IN,
    localparam int TBITS = NENT * OUT
) (
    input  logic [TBITS-1:0] contents,
    input  logic [IN-1:0]    sel,
    output logic [OUT-1:0]   y
);
    logic [OUT-1:0] entry [NENT];

    for (genvar e = 0; e < NENT; e++) begin : g_entry
        assign entry[e] = contents[e*OUT +: OUT];
    end

    always_comb y = entry[sel];
endmodule

// File: rtl/lutcell_fbmux.sv
module lutcell_fbmux #(
    parameter int IN = lutcell_pkg::LUT_IN
) (
    input  logic          use_chain,
    input  logic          chain_bit,
    input  logic [IN-1:0] ext_sel,
    output logic [IN-1:0] sel
);
    always_comb begin
        sel         = ext_sel;
        sel[IN-1]   = use_chain ? chain_bit : ext_sel[IN-1];
    end
endmodule

// File: rtl/lut_pair_cell.sv
module lut_pair_cell #(
    parameter int LUT_IN  = lutcell_pkg::LUT_IN,
    parameter int LUT_OUT = lutcell_pkg::LUT_OUT
) (
    input  logic               cfg_clk,
    input  logic               cfg_rst_n,
    input  logic               cfg_sin,
    input  logic [LUT_IN-1:0]  a_in,
    input  logic [LUT_IN-1:0]  b_in,
    output logic [LUT_OUT-1:0] r_out,
    output logic [LUT_OUT-1:0] l_out
);
    localparam int TBITS = (1 << LUT_IN) * LUT_OUT;
    localparam int CLEN  = 2 * TBITS + 1;
    localparam int L_LSB = 1;
    localparam int R_LSB = L_LSB + TBITS;

    logic [CLEN-1:0]   cfg_word;
    logic [LUT_IN-1:0] left_sel;

    lutcell_chain #(.LEN(CLEN)) u_chain (
        .clk   (cfg_clk),
        .rst_n (cfg_rst_n),
        .sin   (cfg_sin),
        .bits  (cfg_word)
    );

    lutcell_table #(.IN(LUT_IN), .OUT(LUT_OUT)) u_right (
        .contents (cfg_word[R_LSB +: TBITS]),
        .sel      (a_in),
        .y        (r_out)
    );

    lutcell_fbmux #(.IN(LUT_IN)) u_fb (
        .use_chain (cfg_word[0]),
        .chain_bit (r_out[LUT_OUT-1]),
        .ext_sel   (b_in),
        .sel       (left_sel)
    );

    lutcell_table #(.IN(LUT_IN), .OUT(LUT_OUT)) u_left (
        .contents (cfg_word[L_LSB +: TBITS]),
        .sel      (left_sel),
        .y        (l_out)
    );
endmodule

// File: rtl/lut_pair_chk.sv
module lut_pair_chk #(
    parameter int CLEN = lutcell_pkg::CHAIN_LEN
) (
    input logic            cfg_clk,
    input logic            cfg_rst_n,
    input logic            cfg_sin,
    input logic [2:0]      a_in,
    input logic [2:0]      b_in,
    input logic [1:0]      r_out,
    input logic [1:0]      l_out,
    input logic [CLEN-1:0] chain
);
    AST_RESET_CLEAR: assert property (@(posedge cfg_clk)
        !cfg_rst_n |-> (chain == '0)); // R1

    AST_SHIFT_IN: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        1'b1 |=> (chain[0] == $past(cfg_sin))); // R2

    AST_SHIFT_MOVE: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        1'b1 |=> (chain[CLEN-1:1] == $past(chain[CLEN-2:0]))); // R10

    AST_RIGHT_READ: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        r_out == chain[17 + 2*a_in +: 2]); // R5

    AST_LEFT_EXT: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        !chain[0] |-> (l_out == chain[1 + 2*b_in +: 2])); // R6

    AST_LEFT_CHAIN: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        chain[0] |-> (l_out == chain[1 + 2*{r_out[1], b_in[1:0]} +: 2])); // R7
endmodule

bind lut_pair_cell lut_pair_chk u_chk (
    .cfg_clk   (cfg_clk),
    .cfg_rst_n (cfg_rst_n),
    .cfg_sin   (cfg_sin),
    .a_in      (a_in),
    .b_in      (b_in),
    .r_out     (r_out),
    .l_out     (l_out),
    .chain     (cfg_word)
);

// File: tb/sim_lut_pair_cell.sv
`timescale 1ns/1ps
module sim_lut_pair_cell;
    logic clk = 1'b0;
    logic run = 1'b0;
    logic cfg_clk;
    logic cfg_rst_n = 1'b0;
    logic cfg_sin = 1'b0;
    logic [2:0] a_in = '0;
    logic [2:0] b_in = '0;
    logic [1:0] r_out, l_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string tag = "R1";
    bit mq[$];

    always #5 clk = ~clk;
    assign cfg_clk = clk & run;

    lut_pair_cell u0 (
        .cfg_clk(cfg_clk), .cfg_rst_n(cfg_rst_n), .cfg_sin(cfg_sin),
        .a_in(a_in), .b_in(b_in), .r_out(r_out), .l_out(l_out)
    );

    // behavioural model: newest bit at front, 33 kept
    always @(posedge cfg_clk or negedge cfg_rst_n) begin
        if (!cfg_rst_n) mq.delete();
        else begin
            mq.push_front(cfg_sin);
            if (mq.size() > 33) void'(mq.pop_back());
        end
    end

    function automatic logic mb(int i);
        return (i < mq.size()) ? logic'(mq[i]) : 1'b0;
    endfunction

    function automatic logic [1:0] ent(int base, int idx);
        return {mb(base + 2*idx + 1), mb(base + 2*idx)};
    endfunction

    task automatic check(string req, logic [3:0] got, logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic compare(string req);
        logic [1:0] er, el;
        int li;
        er = ent(17, int'(a_in));
        li = mb(0) ? int'({er[1], b_in[1:0]}) : int'(b_in);
        el = ent(1, li);
        check(req, {2'b00, r_out}, {2'b00, er});
        check(req, {2'b00, l_out}, {2'b00, el});
    endtask

    // compare on every clock
    always @(negedge clk) begin
        #1;
        compare(tag);
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog got %0d expected <20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic load(logic [32:0] w);
        for (int i = 32; i >= 0; i--) begin
            @(negedge clk);
            cfg_sin = w[i];
            run = 1'b1;
        end
        @(negedge clk);
        run = 1'b0;
    endtask

    task automatic sweep();
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            a_in = v[2:0];
            b_in = v[5:3];
        end
        @(negedge clk);
    endtask

    function automatic logic [15:0] adder_tbl();
        logic [15:0] t;
        for (int k = 0; k < 8; k++) begin
            logic [2:0] x;
            x = k[2:0];
            t[2*k]   = ^x;
            t[2*k+1] = (x[0] & x[1]) | (x[0] & x[2]) | (x[1] & x[2]);
        end
        return t;
    endfunction

    initial begin
        // R1: reset holds chain clear even with clocks
        tag = "R1";
        run = 1'b1;
        cfg_sin = 1'b1;
        sweep();
        @(negedge clk);
        run = 1'b0;
        cfg_rst_n = 1'b1;
        @(negedge clk);

        // R2/R5/R6: arbitrary pattern, chain select off
        tag = "R2";
        load({16'hB4E1, 16'h3C5A, 1'b0});
        tag = "R6";
        sweep();

        // R7: chain select on, b_in[2] ignored
        tag = "R2";
        load({16'h9A63, 16'hE21D, 1'b1});
        tag = "R7";
        sweep();

        // R4: single bit at right entry 5, bit 0
        tag = "R4";
        load({16'h0400, 16'h0000, 1'b0});
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            a_in = v[2:0];
            #2;
            check("R4", {2'b00, r_out}, (v == 5) ? 4'h1 : 4'h0);
        end

        // R3: single bit at left entry 3, bit 1
        tag = "R3";
        load({16'h0000, 16'h0080, 1'b0});
        @(negedge clk);
        b_in = 3'd3;
        #2;
        check("R3", {2'b00, l_out}, 4'h2);
        @(negedge clk);
        b_in = 3'd7;
        #2;
        check("R3", {2'b00, l_out}, 4'h0);

        // R8: clock gated, sin toggles, inputs move
        load({16'h5AA5, 16'hC33C, 1'b0});
        tag = "R8";
        for (int v = 0; v < 40; v++) begin
            @(negedge clk);
            cfg_sin = v[0];
            a_in = v[2:0];
            b_in = v[5:3];
        end
        sweep();

        // R9: ripple-carry adder
        tag = "R2";
        load({adder_tbl(), adder_tbl(), 1'b1});
        tag = "R9";
        for (int v = 0; v < 32; v++) begin
            logic [1:0] a, b;
            logic ci;
            int s;
            a = v[1:0];
            b = v[3:2];
            ci = v[4];
            @(negedge clk);
            a_in = {ci, b[0], a[0]};
            b_in = {~ci, b[1], a[1]};
            #2;
            s = int'(a) + int'(b) + int'(ci);
            check("R9", {1'b0, l_out, r_out[0]}, 4'(s));
        end

        // R10: 34 bits, oldest 1 drops out
        tag = "R10";
        @(negedge clk);
        cfg_sin = 1'b1;
        run = 1'b1;
        load({16'h0000, 16'h0000, 1'b0});
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            a_in = v[2:0];
            #2;
            check("R10", {2'b00, r_out}, 4'h0);
        end
        sweep();

        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule